// File: doc/BRIEF.md
# Polarity-Aware GPIO Status Register

This block looks after eight general-purpose pins through a small register bus. Each pin has two configuration bits. One sets its direction and the other sets the level that counts as "asserted" for that pin. A single status register holds one bit per pin, and pin n maps to status bit n. For a pin set as an input, the status bit reports whether the pin currently sits at its asserted level. For a pin set as an output, the stored status bit decides whether the pin is driven to its asserted level or to its deasserted level.

Pin inputs pass through a two-stage synchroniser before polarity is applied. Writes to the status register are masked bit by bit: only bits whose pin is currently an output take the written value. Each pin keeps its stored output bit when it changes direction, so turning a pin back into an output drives the last value written to it. A register write uses one strobe cycle. Read data is purely combinational from the address.

Top module: `gpio_polarity_status`

## Requirements
- R1: After reset, every configuration bit and every stored output bit is 0, so all pins are active-low inputs. `pin_oe` is 00h and `pin_out` is FFh. Once the synchroniser has filled with all pins held high, the status register (address 2) reads 00h.
- R2: For an input pin whose polarity bit is 1 (active-high), its status bit reads 1 when the synchronised pin is high and 0 when it is low.
- R3: For an input pin whose polarity bit is 0 (active-low), its status bit reads 1 when the synchronised pin is low and 0 when it is high.
- R4: A change on `pin_in` is invisible in the status read one clock edge later. It becomes visible after the second clock edge.
- R5: Pin n's direction bit is at bit 2*(n mod 4) and its polarity bit is at bit 2*(n mod 4)+1 of configuration register n/4. Configuration register 0 is at address 0 and register 1 is at address 1. `pin_oe[n]` equals the direction bit (1 = output).
- R6: For an output pin, writing 1 to its status bit drives `pin_out[n]` to the asserted level and writing 0 drives the deasserted level. Reading the status register returns the stored bit for that pin.
- R7: A status write leaves the stored bit of every input pin unchanged. This is visible on `pin_out` and in the status read once the pin is made an output.
- R8: When a pin changes from output to input, it stops driving (`pin_oe[n]`=0) and its status bit shows the input assertion. Its stored bit is retained and drives the pin again when it returns to output.
- R9: Address 3 is unused. Writes to it change nothing, and reads of it return 00h.
- R10: A write to a configuration register stores the written byte, and reading that address returns it in the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register address (0,1 configuration, 2 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Level driven on each pin when enabled |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The bench builds the block with its default parameters: eight pins, a two-bit address and a two-stage synchroniser. Eight pins give two configuration registers, so both register slots and the pin-to-register split at pin 4 are exercised. With a two-bit address, address 3 is the one spare address, which the bench writes and reads. The shallow synchroniser makes the exact two-edge input latency observable cycle by cycle. A bench model keeps its own copy of the configuration and stored output bits and predicts the status reads and the pin outputs for mixed directions and polarities.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;

    // Two configuration bits per pin: direction in the low bit, polarity above it.
    localparam int unsigned FIELD_W = 2;

    typedef struct packed {
        logic pol;   // 1 = active-high
        logic dir;   // 1 = output
    } pin_mode_t;

    // A level counts as asserted when it equals the polarity bit.
    function automatic logic is_asserted(input logic lvl, input logic pol);
        return ~(lvl ^ pol);
    endfunction

endpackage

// File: rtl/gs_sync.sv
`timescale 1ns/1ps
module gs_sync #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0][NUM_PINS-1:0] chain;
        logic                            running;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.running  = 1'b1;
        st_d.chain[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.chain[STAGES-1];

    // Each stage holds what its predecessor held one edge earlier (R4 latency).
    for (genvar s = 0; s < STAGES; s++) begin : g_chk
        if (s == 0) begin : g_first
            p_stage_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.running |-> st_q.chain[0] == $past(pin_i));
        end else begin : g_rest
            p_stage_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.running |-> st_q.chain[s] == $past(st_q.chain[s-1]));
        end
    end

endmodule

// File: rtl/gs_cfg_bank.sv
`timescale 1ns/1ps
module gs_cfg_bank
    import gs_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_PINS-1:0]               wdata,
    output logic [(NUM_PINS/(NUM_PINS/FIELD_W))*NUM_PINS-1:0] cfg_flat_o,
    output logic [NUM_PINS-1:0]               dir_o,
    output logic [NUM_PINS-1:0]               pol_o
);

    localparam int unsigned PPC     = NUM_PINS / FIELD_W;   // pins per register
    localparam int unsigned NUM_CFG = NUM_PINS / PPC;

    typedef struct packed {
        logic [NUM_CFG-1:0][NUM_PINS-1:0] regs;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_CFG; k++) begin
            if (wr_en && addr == ADDR_W'(k)) st_d.regs[k] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_flat_o = st_q.regs;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int unsigned REG  = n / PPC;
        localparam int unsigned SLOT = n % PPC;
        pin_mode_t mode;
        assign mode     = pin_mode_t'(st_q.regs[REG][FIELD_W*SLOT +: FIELD_W]);
        assign dir_o[n] = mode.dir;
        assign pol_o[n] = mode.pol;
    end

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_chk
        p_cfg_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(k)) |=> st_q.regs[k] == $past(wdata));
    end

    p_cfg_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.regs));

endmodule

// File: rtl/gs_pin_core.sv
`timescale 1ns/1ps
module gs_pin_core
    import gs_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stat_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] pol_i,
    input  logic [NUM_PINS-1:0] lvl_i,
    output logic [NUM_PINS-1:0] view_o,
    output logic [NUM_PINS-1:0] pin_out_o,
    output logic [NUM_PINS-1:0] pin_oe_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] drive;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stat_i) begin
            st_d.drive = (wdata_i & dir_i) | (st_q.drive & ~dir_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic seen;
        assign seen         = is_asserted(lvl_i[n], pol_i[n]);
        assign view_o[n]    = dir_i[n] ? st_q.drive[n] : seen;
        assign pin_out_o[n] = ~(st_q.drive[n] ^ pol_i[n]);
        assign pin_oe_o[n]  = dir_i[n];
    end

    p_drive_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat_i |=> ((st_q.drive ^ $past(wdata_i)) & $past(dir_i)) == '0);

    p_input_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat_i |=> ((st_q.drive ^ $past(st_q.drive)) & ~$past(dir_i)) == '0);

    p_drive_retained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat_i |=> $stable(st_q.drive));

endmodule

// File: rtl/gpio_polarity_status.sv
`timescale 1ns/1ps
module gpio_polarity_status
    import gs_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam int unsigned PPC         = NUM_PINS / FIELD_W;
    localparam int unsigned NUM_CFG     = NUM_PINS / PPC;
    localparam int unsigned STATUS_ADDR = NUM_CFG;

    logic [NUM_CFG*NUM_PINS-1:0] cfg_flat;
    logic [NUM_PINS-1:0]         dir, pol, lvl, view;
    logic                        wr_stat;

    assign wr_stat = wr_en && (addr == ADDR_W'(STATUS_ADDR));

    gs_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_in),
        .lvl_o (lvl)
    );

    gs_cfg_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .cfg_flat_o (cfg_flat),
        .dir_o      (dir),
        .pol_o      (pol)
    );

    gs_pin_core #(.NUM_PINS(NUM_PINS)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stat_i (wr_stat),
        .wdata_i   (wdata),
        .dir_i     (dir),
        .pol_i     (pol),
        .lvl_i     (lvl),
        .view_o    (view),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe)
    );

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CFG; k++) begin
            if (addr == ADDR_W'(k)) rdata = cfg_flat[k*NUM_PINS +: NUM_PINS];
        end
        if (addr == ADDR_W'(STATUS_ADDR)) rdata = view;
    end

    // The enable of each pin follows the even bit of its configuration field.
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        localparam int unsigned REG  = n / PPC;
        localparam int unsigned SLOT = n % PPC;
        p_oe_from_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(REG)) |=> pin_oe[n] == $past(wdata[FIELD_W*SLOT]));
    end

    p_spare_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_W'(STATUS_ADDR)) |=> ($stable(pin_oe) && $stable(pin_out)));

endmodule

// File: tb/test_gpio_polarity_status.sv
`timescale 1ns/1ps
module test_gpio_polarity_status;

    localparam int NP = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic [NP-1:0] pin_in = 8'hFF;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    always #4 clk = ~clk;   // 125 MHz

    gpio_polarity_status #(.NUM_PINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) i_gpio_polarity_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // kind: 0 = rdata, 1 = pin_out, 2 = pin_oe
    typedef struct {
        int         kind;
        logic [7:0] exp;
        logic [7:0] mask;
        string      req;
    } item_t;

    item_t sbq[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;

    // Bench model, built from the requirements.
    logic [7:0] m_cfg [2];
    logic [7:0] m_drive;
    logic [7:0] m_pins;

    function automatic logic [7:0] m_dir();
        logic [7:0] r;
        for (int n = 0; n < 8; n++) r[n] = m_cfg[n/4][2*(n%4)];
        return r;
    endfunction

    function automatic logic [7:0] m_pol();
        logic [7:0] r;
        for (int n = 0; n < 8; n++) r[n] = m_cfg[n/4][2*(n%4)+1];
        return r;
    endfunction

    function automatic logic [7:0] exp_status(input logic [7:0] pins);
        return (m_drive & m_dir()) | (~(pins ^ m_pol()) & ~m_dir());
    endfunction

    function automatic logic [7:0] exp_out();
        return ~(m_drive ^ m_pol());
    endfunction

    // Monitor: compares queued expectations two ns after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sbq.size() > 0) begin
                item_t      it;
                logic [7:0] act;
                it  = sbq.pop_front();
                act = (it.kind == 0) ? rdata : (it.kind == 1) ? pin_out : pin_oe;
                n_tests++;
                if ((act & it.mask) !== (it.exp & it.mask)) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h (mask %02h)",
                             it.req, it.kind, act & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] exp, input logic [7:0] mask,
                        input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.mask = mask; it.req = req;
        sbq.push_back(it);
    endtask

    // All tasks start and end at a falling edge.
    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        logic [7:0] dm;
        dm    = m_dir();
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 2)       m_cfg[a] = d;
        else if (a == 2) m_drive = (d & dm) | (m_drive & ~dm);
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [7:0] exp,
                             input logic [7:0] mask, input string req);
        addr = a;
        push(0, exp, mask, req);
        @(negedge clk);
    endtask

    task automatic expect_pin(input int kind, input logic [7:0] exp, input logic [7:0] mask,
                              input string req);
        push(kind, exp, mask, req);
        @(negedge clk);
    endtask

    task automatic set_pins(input logic [7:0] v);
        pin_in = v;
        @(negedge clk);
        @(negedge clk);
        m_pins = v;
    endtask

    initial begin
        m_cfg[0] = 8'h00; m_cfg[1] = 8'h00; m_drive = 8'h00; m_pins = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);

        // R1: reset state
        expect_rd(0, 8'h00, 8'hFF, "R1 cfg0 reset");
        expect_rd(1, 8'h00, 8'hFF, "R1 cfg1 reset");
        expect_rd(2, 8'h00, 8'hFF, "R1 status reset");
        expect_pin(2, 8'h00, 8'hFF, "R1 oe reset");
        expect_pin(1, 8'hFF, 8'hFF, "R1 pin_out reset");

        // R9: spare address
        expect_rd(3, 8'h00, 8'hFF, "R9 spare read");
        bus_write(3, 8'hFF);
        expect_rd(0, 8'h00, 8'hFF, "R9 cfg0 after spare write");
        expect_rd(1, 8'h00, 8'hFF, "R9 cfg1 after spare write");
        expect_pin(2, 8'h00, 8'hFF, "R9 oe after spare write");
        expect_rd(2, exp_status(m_pins), 8'hFF, "R9 status after spare write");

        // R10: configuration readback
        bus_write(0, 8'h5A);
        bus_write(1, 8'hC3);
        expect_rd(0, 8'h5A, 8'hFF, "R10 cfg0 readback");
        expect_rd(1, 8'hC3, 8'hFF, "R10 cfg1 readback");

        // R2 / R3: inputs, low nibble active-high, high nibble active-low
        bus_write(0, 8'hAA);
        bus_write(1, 8'h00);
        set_pins(8'h53);
        expect_rd(2, 8'h03, 8'h0F, "R2 active-high inputs");
        expect_rd(2, 8'hA0, 8'hF0, "R3 active-low inputs");

        // R4: two-edge latency
        pin_in = 8'hAC;
        expect_rd(2, exp_status(m_pins), 8'hFF, "R4 one edge after change");
        expect_rd(2, exp_status(8'hAC), 8'hFF, "R4 two edges after change");
        m_pins = 8'hAC;

        // R7: status write with all pins inputs
        bus_write(2, 8'hFF);
        expect_rd(2, exp_status(m_pins), 8'hFF, "R7 status after write to inputs");

        // R5: mixed directions
        bus_write(0, 8'h27);
        bus_write(1, 8'hC7);
        expect_pin(2, 8'hB3, 8'hFF, "R5 oe from even bits");
        expect_pin(1, exp_out(), 8'hFF, "R7 stored bits untouched by input write");

        // R6: drive asserted then deasserted
        bus_write(2, 8'hFF);
        expect_pin(1, exp_out(), 8'hFF, "R6 drive asserted");
        expect_pin(1, 8'h91, 8'hB3, "R6 asserted levels per polarity");
        expect_rd(2, exp_status(m_pins), 8'hFF, "R6 status read mixed");
        bus_write(2, 8'h00);
        expect_pin(1, exp_out(), 8'hFF, "R6 drive deasserted");

        // R8: output to input and back
        bus_write(2, 8'h01);
        bus_write(0, 8'h26);
        expect_pin(2, 8'h00, 8'h01, "R8 pin0 released");
        expect_rd(2, exp_status(m_pins), 8'hFF, "R8 status shows input");
        bus_write(0, 8'h27);
        expect_pin(1, 8'h01, 8'h01, "R8 retained bit drives again");
        expect_rd(2, exp_status(m_pins), 8'hFF, "R8 status shows stored bit");

        // R7: pin2 write ignored while input, seen after it turns output
        bus_write(2, 8'hFF);
        bus_write(0, 8'h37);
        expect_pin(1, exp_out(), 8'hFF, "R7 pin2 kept old stored bit");
        expect_rd(2, exp_status(m_pins), 8'hFF, "R7 status after direction change");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule